// File: doc/BRIEF.md
# Home-Node Directory Read Controller

This block is the home side of a directory protocol in a cache-coherent machine whose memory is spread over several nodes. Read requests reach it from the interconnect. Each request carries a 32-bit physical address and the number of the node that sent it. The controller splits the address, checks that the line is homed here, and looks up that line's directory entry. It then does one of three things: it fetches the line from local memory and sends it back, it tells the requester which node already holds the line, or it rejects the request.

Each directory entry records a single holder: a cached flag and one node number. After a line is fetched and returned, its entry is written to name the requester. The controller works on one request at a time and steps through the states idle, lookup, fetch, reply and update. The directory has fewer entries than a full-size home node (parameter `DIR_IDX_W`). Local memory lies outside the block, behind a simple synchronous read port.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is uncached, `req_ready` is 1, and `rsp_valid` and `mem_rd_en` are 0.
- R2: The address fields are node = addr[31:24], line = addr[23:6] and offset = addr[5:0]. The offset has no effect on the outcome. With `HOME_NODE` = 36, address 0x24000108 selects line 4 of this node.
- R3: A request for an uncached line gets a response with `rsp_kind` = 0 (data). It has `rsp_dest` equal to the requester and `rsp_data` equal to the memory word of that line.
- R4: After a data response, the entry names the requester. A later request for that line from a different node gets `rsp_kind` = 1 (holder), with `rsp_owner` equal to the recorded node, and no memory read.
- R5: A holder response leaves the entry unchanged, so further requests from other nodes see the same holder.
- R6: A request whose node field differs from `HOME_NODE` gets `rsp_kind` = 2 (error), causes no memory read, and changes no directory entry.
- R7: A line field at or above 2^`DIR_IDX_W` gets an error response, causes no memory read, and leaves the entry that shares its low bits unchanged.
- R8: `req_ready` falls on the edge that accepts a request. It stays low until the response, and for a data response until the entry write, is complete.
- R9: `rsp_valid` rises `MEM_LAT`+2 edges after the accepting edge for a data response, and 1 edge after it for holder and error responses.
- R10: Each data response is preceded by exactly one single-cycle `mem_rd_en` pulse whose `mem_rd_line` equals the line field.
- R11: A request from the node already recorded as holder is served with data again.
- R12: `rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_addr | input | 32 | Physical address of the requested line |
| req_src | input | 8 | Requesting node number |
| mem_rd_en | output | 1 | Local memory read strobe |
| mem_rd_line | output | 18 | Line number to read |
| mem_rd_data | input | 64 | Line data from local memory |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_kind | output | 2 | 0 data, 1 holder, 2 error |
| rsp_dest | output | 8 | Node the response goes to |
| rsp_owner | output | 8 | Recorded holder on a holder response |
| rsp_data | output | 64 | Line data on a data response |

## Verification
The hardest case to reach from the ports is showing that a request which must not change the directory really left it alone. A wrong write would be invisible until some later request for the same entry. Each error or holder request is therefore followed by a request from a fresh node for the entry it could have touched. For an out-of-range line, that is the line sharing its low index bits. The bench then checks that the data path or the old holder is still what it was.

// File: rtl/dir_home_pkg.sv
// Shared encodings for the home-node directory controller.
package dir_home_pkg;
    // Response kinds carried on rsp_kind
    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_OWNER = 2'd1,
        RSP_ERROR = 2'd2
    } rsp_kind_e;

    // Controller sequence states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH,
        ST_REPLY,
        ST_UPDATE
    } ctl_state_e;
endpackage

// File: rtl/dir_addr_split.sv
// Splits a physical address into node, line and directory index.
// Flags whether the line is homed here and fits the reduced directory.
// Assumes the offset field is the low OFFS_W bits and the node field is on top.
module dir_addr_split #(
    parameter int ADDR_W    = 32,
    parameter int NODE_W    = 8,
    parameter int OFFS_W    = 6,
    parameter int LINE_W    = ADDR_W - NODE_W - OFFS_W,
    parameter int IDX_W     = 4,
    parameter int HOME_NODE = 36
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LINE_W-1:0] line,
    output logic [IDX_W-1:0]  idx,
    output logic              home_hit,
    output logic              in_range
);
    logic [NODE_W-1:0] node_f;

    // Field extraction and range checks
    always_comb begin
        node_f   = addr[ADDR_W-1 -: NODE_W];
        line     = addr[OFFS_W +: LINE_W];
        idx      = line[IDX_W-1:0];
        home_hit = (node_f == NODE_W'(HOME_NODE));
        in_range = ((line >> IDX_W) == '0);
    end
endmodule

// File: rtl/dir_table.sv
// Single-holder directory: one cached flag and one holder node per entry.
// Combinational read, one synchronous write port, all entries cleared on reset.
module dir_table #(
    parameter int NODE_W = 8,
    parameter int IDX_W  = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_cached,
    output logic [NODE_W-1:0] rd_owner,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [NODE_W-1:0] wr_owner
);
    logic              cached_q [DEPTH];
    logic [NODE_W-1:0] owner_q  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Entry e: cleared on reset, set with the new holder on write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cached_q[e] <= 1'b0;
                owner_q[e]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                cached_q[e] <= 1'b1;
                owner_q[e]  <= wr_owner;
            end
        end
    end

    // Read port
    always_comb begin
        rd_cached = cached_q[rd_idx];
        rd_owner  = owner_q[rd_idx];
    end
endmodule

// File: rtl/dir_home_fsm.sv
// Request sequencer: accepts one request, decides the response from the
// decode flags and directory entry, waits MEM_LAT cycles for a fetch,
// replies, then records the new holder. Assumes MEM_LAT >= 1 and that
// memory data is held stable once available.
module dir_home_fsm
    import dir_home_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NODE_W  = 8,
    parameter int DATA_W  = 64,
    parameter int MEM_LAT = 3,
    localparam int CNT_W  = $clog2(MEM_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NODE_W-1:0] req_src,
    output logic [ADDR_W-1:0] cur_addr,
    input  logic              home_hit,
    input  logic              in_range,
    input  logic              ent_cached,
    input  logic [NODE_W-1:0] ent_owner,
    output logic              dir_wr_en,
    output logic [NODE_W-1:0] dir_wr_owner,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [NODE_W-1:0] rsp_dest,
    output logic [NODE_W-1:0] rsp_owner,
    output logic [DATA_W-1:0] rsp_data
);
    ctl_state_e        state;
    rsp_kind_e         kind_q;
    logic [CNT_W-1:0]  wait_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NODE_W-1:0] src_q;
    logic [NODE_W-1:0] owner_q;
    logic [DATA_W-1:0] data_q;

    // Sequencing and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind_q  <= RSP_DATA;
            wait_q  <= '0;
            addr_q  <= '0;
            src_q   <= '0;
            owner_q <= '0;
            data_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        src_q  <= req_src;
                        state  <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    wait_q <= '0;
                    data_q <= '0;
                    if (!home_hit || !in_range) begin
                        kind_q  <= RSP_ERROR;
                        owner_q <= '0;
                        state   <= ST_REPLY;
                    end else if (ent_cached && (ent_owner != src_q)) begin
                        kind_q  <= RSP_OWNER;
                        owner_q <= ent_owner;
                        state   <= ST_REPLY;
                    end else begin
                        kind_q  <= RSP_DATA;
                        owner_q <= src_q;
                        state   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (wait_q == CNT_W'(MEM_LAT)) begin
                        data_q <= mem_rd_data;
                        state  <= ST_REPLY;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_REPLY: state <= (kind_q == RSP_DATA) ? ST_UPDATE : ST_IDLE;
                ST_UPDATE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state and captured fields
    always_comb begin
        req_ready    = (state == ST_IDLE);
        cur_addr     = addr_q;
        mem_rd_en    = (state == ST_FETCH) && (wait_q == '0);
        dir_wr_en    = (state == ST_UPDATE);
        dir_wr_owner = src_q;
        rsp_valid    = (state == ST_REPLY);
        rsp_kind     = kind_q;
        rsp_dest     = src_q;
        rsp_owner    = owner_q;
        rsp_data     = data_q;
    end
endmodule

// File: rtl/dir_home_ctrl.sv
// Home-node directory read controller, top level.
// Wires the address splitter, directory table and sequencer together.
// Assumes local memory sits outside with a synchronous read port.
module dir_home_ctrl #(
    parameter int ADDR_W    = 32,
    parameter int NODE_W    = 8,
    parameter int OFFS_W    = 6,
    parameter int DATA_W    = 64,
    parameter int DIR_IDX_W = 4,
    parameter int HOME_NODE = 36,
    parameter int MEM_LAT   = 3,
    localparam int LINE_W   = ADDR_W - NODE_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NODE_W-1:0] req_src,
    output logic              mem_rd_en,
    output logic [LINE_W-1:0] mem_rd_line,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [NODE_W-1:0] rsp_dest,
    output logic [NODE_W-1:0] rsp_owner,
    output logic [DATA_W-1:0] rsp_data
);
    logic [ADDR_W-1:0]    cur_addr;
    logic [LINE_W-1:0]    cur_line;
    logic [DIR_IDX_W-1:0] cur_idx;
    logic                 home_hit;
    logic                 in_range;
    logic                 ent_cached;
    logic [NODE_W-1:0]    ent_owner;
    logic                 dir_wr_en;
    logic [NODE_W-1:0]    dir_wr_owner;

    dir_addr_split #(
        .ADDR_W(ADDR_W), .NODE_W(NODE_W), .OFFS_W(OFFS_W),
        .LINE_W(LINE_W), .IDX_W(DIR_IDX_W), .HOME_NODE(HOME_NODE)
    ) i_split (
        .addr(cur_addr), .line(cur_line), .idx(cur_idx),
        .home_hit(home_hit), .in_range(in_range)
    );

    dir_table #(.NODE_W(NODE_W), .IDX_W(DIR_IDX_W)) i_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(cur_idx), .rd_cached(ent_cached), .rd_owner(ent_owner),
        .wr_en(dir_wr_en), .wr_idx(cur_idx), .wr_owner(dir_wr_owner)
    );

    dir_home_fsm #(
        .ADDR_W(ADDR_W), .NODE_W(NODE_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_src(req_src),
        .cur_addr(cur_addr), .home_hit(home_hit), .in_range(in_range),
        .ent_cached(ent_cached), .ent_owner(ent_owner),
        .dir_wr_en(dir_wr_en), .dir_wr_owner(dir_wr_owner),
        .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dest(rsp_dest),
        .rsp_owner(rsp_owner), .rsp_data(rsp_data)
    );

    // Memory line index follows the decoded line field
    always_comb mem_rd_line = cur_line;
endmodule

// File: rtl/dir_home_checks.sv
// Protocol checks for dir_home_ctrl, attached by bind.
module dir_home_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       mem_rd_en,
    input logic       rsp_valid,
    input logic [1:0] rsp_kind
);
    // R8: accepting a request makes the controller busy on the next cycle
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: no new request is taken while a response is out
    p_reply_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R12: response strobe lasts one cycle
    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: memory read strobe lasts one cycle
    p_read_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R6: holder and error replies come straight from lookup, not after a read
    p_no_read_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind != 2'd0)) |-> !$past(mem_rd_en));
endmodule

bind dir_home_ctrl dir_home_checks i_checks (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind)
);

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
// Directed bench for dir_home_ctrl: one task per scenario.
module test_dir_home_ctrl;
    localparam int HOME    = 36;
    localparam int MEM_LAT = 3;
    localparam int IDX_W   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_src = '0;
    logic        mem_rd_en;
    logic [17:0] mem_rd_line;
    logic [63:0] mem_rd_data;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [7:0]  rsp_dest;
    logic [7:0]  rsp_owner;
    logic [63:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dir_home_ctrl #(.DIR_IDX_W(IDX_W), .HOME_NODE(HOME), .MEM_LAT(MEM_LAT)) i_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_src(req_src), .mem_rd_en(mem_rd_en),
        .mem_rd_line(mem_rd_line), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dest(rsp_dest),
        .rsp_owner(rsp_owner), .rsp_data(rsp_data)
    );

    // Line contents as a function of line number
    function automatic logic [63:0] line_word(input int ln);
        return {32'hA5A5_0000 | 32'(ln), ~32'(ln)};
    endfunction

    function automatic logic [31:0] mk_addr(input int node, input int ln, input int off);
        return {8'(node), 18'(ln), 6'(off)};
    endfunction

    // Local memory: synchronous read, one cycle
    logic [63:0] mem [1 << IDX_W];
    initial for (int i = 0; i < (1 << IDX_W); i++) mem[i] = line_word(i);
    always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_line[IDX_W-1:0]];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request; report response fields, latency and read activity
    task automatic send(input logic [31:0] a, input logic [7:0] s,
                        output logic [1:0] kind, output logic [7:0] dest,
                        output logic [7:0] own, output logic [63:0] data,
                        output int lat, output int reads, output logic [17:0] rline,
                        output bit busy_ok);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_src = s; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; reads = 0; rline = '0; busy_ok = !req_ready;
        while (!rsp_valid && lat < 100) begin
            if (mem_rd_en) begin reads++; rline = mem_rd_line; end
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        kind = rsp_kind; dest = rsp_dest; own = rsp_owner; data = rsp_data;
        @(negedge clk);
        check(!rsp_valid, "R12 rsp_valid width", 64'(rsp_valid), 64'd0);
    endtask

    task automatic expect_data(input int ln, input int off, input int s, input string tag);
        logic [1:0] k; logic [7:0] d, o; logic [63:0] dt; int lat, rd; logic [17:0] rl; bit bz;
        send(mk_addr(HOME, ln, off), 8'(s), k, d, o, dt, lat, rd, rl, bz);
        check(k == 2'd0, {tag, " R3 kind"}, 64'(k), 64'd0);
        check(d == 8'(s), {tag, " R3 dest"}, 64'(d), 64'(s));
        check(dt == line_word(ln), {tag, " R3 data"}, dt, line_word(ln));
        check(lat == MEM_LAT + 3, {tag, " R9 data latency"}, 64'(lat), 64'(MEM_LAT + 3));
        check(rd == 1 && rl == 18'(ln), {tag, " R10 single read of line"}, 64'(rl), 64'(ln));
        check(bz, {tag, " R8 busy until reply"}, 64'(bz), 64'd1);
    endtask

    task automatic expect_owner(input int ln, input int s, input int holder, input string tag);
        logic [1:0] k; logic [7:0] d, o; logic [63:0] dt; int lat, rd; logic [17:0] rl; bit bz;
        send(mk_addr(HOME, ln, 0), 8'(s), k, d, o, dt, lat, rd, rl, bz);
        check(k == 2'd1, {tag, " R4 kind"}, 64'(k), 64'd1);
        check(o == 8'(holder), {tag, " R4 owner"}, 64'(o), 64'(holder));
        check(d == 8'(s), {tag, " R4 dest"}, 64'(d), 64'(s));
        check(rd == 0, {tag, " R4 no read"}, 64'(rd), 64'd0);
        check(lat == 2, {tag, " R9 holder latency"}, 64'(lat), 64'd2);
    endtask

    task automatic expect_error(input logic [31:0] a, input int s, input string tag);
        logic [1:0] k; logic [7:0] d, o; logic [63:0] dt; int lat, rd; logic [17:0] rl; bit bz;
        send(a, 8'(s), k, d, o, dt, lat, rd, rl, bz);
        check(k == 2'd2, {tag, " kind"}, 64'(k), 64'd2);
        check(rd == 0, {tag, " no read"}, 64'(rd), 64'd0);
        check(lat == 2, {tag, " R9 error latency"}, 64'(lat), 64'd2);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        check(mem_rd_en == 1'b0, "R1 no read after reset", 64'(mem_rd_en), 64'd0);
    endtask

    // R2: worked address example, node 36 line 4 offset 8, from node 20
    task automatic t_decode_example();
        logic [1:0] k; logic [7:0] d, o; logic [63:0] dt; int lat, rd; logic [17:0] rl; bit bz;
        send(32'h2400_0108, 8'd20, k, d, o, dt, lat, rd, rl, bz);
        check(k == 2'd0 && rl == 18'd4, "R2 example decodes to line 4", 64'(rl), 64'd4);
        check(dt == line_word(4), "R2 R3 example data", dt, line_word(4));
    endtask

    task automatic t_holder();
        expect_owner(4, 7, 20, "holder A");
        expect_owner(4, 9, 20, "R5 holder kept");
    endtask

    task automatic t_same_holder();
        expect_data(4, 0, 20, "R11 repeat by holder");
        expect_owner(4, 3, 20, "R11 R5 holder after repeat");
    endtask

    task automatic t_foreign_node();
        expect_error(mk_addr(HOME + 1, 5, 0), 3, "R6 foreign node");
        expect_data(5, 0, 11, "R6 entry 5 untouched");
    endtask

    task automatic t_out_of_range();
        expect_error(mk_addr(HOME, (1 << IDX_W) + 6, 0), 3, "R7 line beyond directory");
        expect_data(6, 0, 12, "R7 aliased entry untouched");
    endtask

    task automatic t_offsets();
        expect_data(7, 63, 1, "R2 offset ignored");
        expect_owner(7, 2, 1, "R2 offset line holder");
        expect_data(15, 17, 200, "R1 top entry uncached");
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode_example();
        t_holder();
        t_same_holder();
        t_foreign_node();
        t_out_of_range();
        t_offsets();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule